// File: doc/BRIEF.md
# Exception Entry Controller

This block chooses which pending exception a small 32-bit RISC core takes and performs the entry into its handler. The core presents its request lines for the cycle, together with the current PC, the normal and debug vector base registers, the remap flag from its debug control register and the three interrupt-enable bits. The block masks the external interrupt with the global enable, picks the winning request by fixed priority and, one clock later, returns a single-cycle entry pulse with the handler address, a link-register write (index and data) and the new enable bits.

Exceptions fall into two classes. Breakpoint and watchpoint are debug exceptions: they save the PC in the breakpoint link register, shadow the global enable into the breakpoint-enable bit and always vector from the debug base. The other five are normal exceptions: they save the PC in the exception link register, shadow the global enable into the exception-enable bit and vector from the normal base, unless the remap flag sends them to the debug base. All pins are plain control and status signals; no valid/ready handshake is involved, because the core must act on an entry in the cycle it is reported.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On entry, `vec_pc_o` equals the selected base with its low 8 bits forced to zero, plus the exception code times 32.
- R2: Exception codes are breakpoint 1, instruction bus error 2, watchpoint 3, data bus error 4, divide by zero 5, interrupt 6, system call 7 (0 is reserved for reset and is never requested here); when several requests are pending, the lowest code wins and is reported on `exc_code_o`.
- R3: On a normal exception (codes 2, 4, 5, 6, 7), `lr_we_o` is high, `lr_idx_o` is 30 and `lr_data_o` equals the PC presented with the request.
- R4: On a debug exception (codes 1, 3), `lr_we_o` is high, `lr_idx_o` is 31 and `lr_data_o` equals the PC presented with the request.
- R5: With enable bits packed as bit 0 global enable, bit 1 exception-enable shadow, bit 2 breakpoint-enable shadow, a normal entry outputs bit 0 cleared, bit 1 set if it was set or if the global enable was set, and bit 2 unchanged.
- R6: A debug entry outputs bit 0 cleared, bit 2 set if it was set or if the global enable was set, and bit 1 unchanged.
- R7: A normal exception vectors from `eba_in` when `remap_in` is low and from `deba_in` when it is high.
- R8: A debug exception vectors from `deba_in` whatever the value of `remap_in`.
- R9: The interrupt request is ignored while the global enable (bit 0 of `ie_in`) is low: alone it produces no entry, and with other requests it cannot win.
- R10: Each cycle with at least one eligible request produces exactly one entry pulse (`take_o`, `lr_we_o`, `ie_we_o` high) on the following cycle; a cycle with none leaves them low on the following cycle.
- R11: During and straight after reset, `take_o`, `lr_we_o` and `ie_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_brk | input | 1 | Breakpoint request |
| req_ibus | input | 1 | Instruction bus error request |
| req_wp | input | 1 | Watchpoint request |
| req_dbus | input | 1 | Data bus error request |
| req_div | input | 1 | Divide-by-zero request |
| req_irq | input | 1 | External interrupt request |
| req_scall | input | 1 | System call request |
| pc_in | input | 32 | PC of the faulting or interrupted instruction |
| eba_in | input | 32 | Normal vector base |
| deba_in | input | 32 | Debug vector base |
| remap_in | input | 1 | Send normal exceptions to the debug base |
| ie_in | input | 3 | Current enable bits (bit 0 global, bit 1 exception shadow, bit 2 breakpoint shadow) |
| take_o | output | 1 | Entry pulse |
| exc_code_o | output | 3 | Code of the exception taken |
| vec_pc_o | output | 32 | Handler address |
| lr_we_o | output | 1 | Link register write enable |
| lr_idx_o | output | 5 | Link register index |
| lr_data_o | output | 32 | Value written to the link register |
| ie_we_o | output | 1 | Enable bits write enable |
| ie_o | output | 3 | New enable bits |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 8-bit base alignment, 32-byte vector spacing and link register indices 30 and 31. With these values every code offset stays below the base alignment, so random bases with nonzero low bits show whether the alignment mask is applied before the offset is added. Random request mixes, enable states and remap values reach every priority pairing, while directed cases cover the masked interrupt alone and beside a system call, all requests at once, and debug entry with the global enable already low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_BRK   = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIV   = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } exc_code_e;

  // Enable bits: global enable in bit 0.
  typedef struct packed {
    logic bie;
    logic eie;
    logic ie;
  } ie_state_t;

  function automatic logic is_debug_code(input exc_code_e c);
    return (c == EXC_BRK) || (c == EXC_WATCH);
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [N-1:0] lower_any;
  logic [N-1:0] grant;

  assign lower_any[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_chain
      assign lower_any[g] = lower_any[g-1] | pend[g-1];
    end
  endgenerate

  assign grant = pend & ~lower_any;
  assign any   = |pend;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end

  // R2: at most one request is granted, and one whenever any is pending
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));

  // R2: nothing below the winner is pending
  p_lowest_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (pend[idx] && ((pend & ((N'(1) << idx) - N'(1))) == '0)));

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int BASE_LSB  = 8,
  parameter int VEC_SHIFT = 5
) (
  input  exc_code_e       code,
  input  logic            remap,
  input  logic [XLEN-1:0] eba,
  input  logic [XLEN-1:0] deba,
  output logic [XLEN-1:0] vec
);

  logic            use_debug_base;
  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] base_aligned;
  logic [XLEN-1:0] offset;

  assign use_debug_base = is_debug_code(code) | remap;
  assign base_sel       = use_debug_base ? deba : eba;
  assign base_aligned   = {base_sel[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign offset         = XLEN'(code) << VEC_SHIFT;
  assign vec            = base_aligned + offset;

endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
  import exc_entry_pkg::*;
(
  input  ie_state_t cur,
  input  logic      debug,
  output ie_state_t nxt
);

  always_comb begin
    nxt    = cur;
    nxt.ie = 1'b0;
    if (debug) nxt.bie = cur.bie | cur.ie;
    else       nxt.eie = cur.eie | cur.ie;
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int BASE_LSB  = 8,
  parameter int VEC_SHIFT = 5,
  parameter int RIDX_W    = 5,
  parameter int EA_IDX    = 30,
  parameter int BA_IDX    = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_brk,
  input  logic              req_ibus,
  input  logic              req_wp,
  input  logic              req_dbus,
  input  logic              req_div,
  input  logic              req_irq,
  input  logic              req_scall,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   eba_in,
  input  logic [XLEN-1:0]   deba_in,
  input  logic              remap_in,
  input  logic [2:0]        ie_in,
  output logic              take_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic [XLEN-1:0]   vec_pc_o,
  output logic              lr_we_o,
  output logic [RIDX_W-1:0] lr_idx_o,
  output logic [XLEN-1:0]   lr_data_o,
  output logic              ie_we_o,
  output logic [2:0]        ie_o
);

  localparam logic [RIDX_W-1:0] EA_R = RIDX_W'(EA_IDX);
  localparam logic [RIDX_W-1:0] BA_R = RIDX_W'(BA_IDX);

  ie_state_t          ie_cur;
  ie_state_t          ie_nxt;
  logic [NUM_CODES-1:0] pend;
  logic               any_pend;
  logic [CODE_W-1:0]  win_idx;
  exc_code_e          win_code;
  logic               win_debug;
  logic [XLEN-1:0]    vec_nxt;

  assign ie_cur = ie_state_t'(ie_in);

  always_comb begin
    pend            = '0;
    pend[EXC_BRK]   = req_brk;
    pend[EXC_IBUS]  = req_ibus;
    pend[EXC_WATCH] = req_wp;
    pend[EXC_DBUS]  = req_dbus;
    pend[EXC_DIV]   = req_div;
    pend[EXC_IRQ]   = req_irq & ie_cur.ie;
    pend[EXC_SCALL] = req_scall;
  end

  exc_prio_sel #(.N(NUM_CODES)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .any   (any_pend),
    .idx   (win_idx)
  );

  assign win_code  = exc_code_e'(win_idx);
  assign win_debug = is_debug_code(win_code);

  exc_vector_gen #(
    .XLEN      (XLEN),
    .BASE_LSB  (BASE_LSB),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_vec (
    .code  (win_code),
    .remap (remap_in),
    .eba   (eba_in),
    .deba  (deba_in),
    .vec   (vec_nxt)
  );

  exc_ie_update u_ie (
    .cur   (ie_cur),
    .debug (win_debug),
    .nxt   (ie_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      lr_we_o    <= 1'b0;
      ie_we_o    <= 1'b0;
      exc_code_o <= '0;
      vec_pc_o   <= '0;
      lr_idx_o   <= '0;
      lr_data_o  <= '0;
      ie_o       <= '0;
    end else begin
      take_o  <= any_pend;
      lr_we_o <= any_pend;
      ie_we_o <= any_pend;
      if (any_pend) begin
        exc_code_o <= win_idx;
        vec_pc_o   <= vec_nxt;
        lr_idx_o   <= win_debug ? BA_R : EA_R;
        lr_data_o  <= pc_in;
        ie_o       <= ie_nxt;
      end
    end
  end

  // R10: an eligible request produces an entry on the next cycle
  p_entry_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_brk | req_ibus | req_wp | req_dbus | req_div | req_scall | (req_irq & ie_in[0]))
      |=> (take_o && lr_we_o && ie_we_o));

  // R9: a masked interrupt on its own produces no entry
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && !ie_in[0] &&
     !(req_brk | req_ibus | req_wp | req_dbus | req_div | req_scall)) |=> !take_o);

  // R1: handlers sit on 32-byte boundaries
  p_vec_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (vec_pc_o[VEC_SHIFT-1:0] == '0));

  // R4: the breakpoint link register is used only by debug codes
  p_ba_debug_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && lr_idx_o == BA_R) |-> (exc_code_o == EXC_BRK || exc_code_o == EXC_WATCH));

  // R5: normal entry shadows the old global enable and clears it
  p_eie_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && lr_idx_o == EA_R) |->
      (!ie_o[0] && ie_o[1] == ($past(ie_in[1]) | $past(ie_in[0])) && ie_o[2] == $past(ie_in[2])));

  // R6: debug entry shadows the old global enable and clears it
  p_bie_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && lr_idx_o == BA_R) |->
      (!ie_o[0] && ie_o[2] == ($past(ie_in[2]) | $past(ie_in[0])) && ie_o[1] == $past(ie_in[1])));

endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_brk = 0, req_ibus = 0, req_wp = 0, req_dbus = 0;
  logic        req_div = 0, req_irq = 0, req_scall = 0;
  logic [31:0] pc_in = '0, eba_in = '0, deba_in = '0;
  logic        remap_in = 1'b0;
  logic [2:0]  ie_in = '0;
  logic        take_o, lr_we_o, ie_we_o;
  logic [2:0]  exc_code_o, ie_o;
  logic [31:0] vec_pc_o, lr_data_o;
  logic [4:0]  lr_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_brk(req_brk), .req_ibus(req_ibus), .req_wp(req_wp), .req_dbus(req_dbus),
    .req_div(req_div), .req_irq(req_irq), .req_scall(req_scall),
    .pc_in(pc_in), .eba_in(eba_in), .deba_in(deba_in), .remap_in(remap_in),
    .ie_in(ie_in), .take_o(take_o), .exc_code_o(exc_code_o), .vec_pc_o(vec_pc_o),
    .lr_we_o(lr_we_o), .lr_idx_o(lr_idx_o), .lr_data_o(lr_data_o),
    .ie_we_o(ie_we_o), .ie_o(ie_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // request vector indexed by code: bit1 brk ... bit7 scall
  function automatic logic [7:0] req_vec();
    return {req_scall, req_irq & ie_in[0], req_div, req_dbus, req_wp, req_ibus, req_brk, 1'b0};
  endfunction

  function automatic int exp_code(input logic [7:0] v);
    for (int i = 1; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] exp_vec(input int c, input logic rm,
                                          input logic [31:0] e, input logic [31:0] d);
    logic [31:0] b;
    b = ((c == 1) || (c == 3) || rm) ? d : e;
    return {b[31:8], 8'h00} + 32'(c * 32);
  endfunction

  function automatic logic [2:0] exp_ie(input int c, input logic [2:0] s);
    logic [2:0] r;
    r = s;
    r[0] = 1'b0;
    if ((c == 1) || (c == 3)) r[2] = s[2] | s[0];
    else                      r[1] = s[1] | s[0];
    return r;
  endfunction

  // drive at negedge, let one rising edge pass, check at the following negedge
  task automatic step(input string note);
    logic [7:0]  v;
    int          c;
    logic [31:0] pc_s, e_s, d_s;
    logic        rm_s;
    logic [2:0]  ie_s;
    v = req_vec(); c = exp_code(v);
    pc_s = pc_in; e_s = eba_in; d_s = deba_in; rm_s = remap_in; ie_s = ie_in;
    @(posedge clk);
    @(negedge clk);
    if (c == 0) begin
      chk(!take_o && !lr_we_o && !ie_we_o, {note, " R10/R9 no entry"}, {29'd0, take_o, lr_we_o, ie_we_o}, 32'd0);
    end else begin
      chk(take_o && lr_we_o && ie_we_o, {note, " R10 entry pulse"}, {29'd0, take_o, lr_we_o, ie_we_o}, 32'd7);
      chk(exc_code_o == 3'(c), {note, " R2 code"}, 32'(exc_code_o), 32'(c));
      chk(vec_pc_o == exp_vec(c, rm_s, e_s, d_s), {note, " R1/R7/R8 vector"}, vec_pc_o, exp_vec(c, rm_s, e_s, d_s));
      if ((c == 1) || (c == 3))
        chk(lr_idx_o == 5'd31, {note, " R4 link idx"}, 32'(lr_idx_o), 32'd31);
      else
        chk(lr_idx_o == 5'd30, {note, " R3 link idx"}, 32'(lr_idx_o), 32'd30);
      chk(lr_data_o == pc_s, {note, " R3/R4 link data"}, lr_data_o, pc_s);
      chk(ie_o == exp_ie(c, ie_s), {note, " R5/R6 enables"}, 32'(ie_o), 32'(exp_ie(c, ie_s)));
    end
  endtask

  task automatic set_req(input logic [7:0] v);
    {req_scall, req_irq, req_div, req_dbus, req_wp, req_ibus, req_brk} = v[7:1];
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(!take_o && !lr_we_o && !ie_we_o, "R11 reset outputs", {29'd0, take_o, lr_we_o, ie_we_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!take_o && !lr_we_o && !ie_we_o, "R11 after reset", {29'd0, take_o, lr_we_o, ie_we_o}, 32'd0);

    pc_in = 32'h0000_1234; eba_in = 32'h1000_00ff; deba_in = 32'h2000_0081; remap_in = 0;

    // R9: masked interrupt alone, then beside a system call
    ie_in = 3'b000; set_req(8'b0100_0000); step("irq masked");
    ie_in = 3'b110; set_req(8'b1100_0000); step("irq masked with scall");
    ie_in = 3'b001; set_req(8'b0100_0000); step("irq enabled");
    // R2: everything pending
    ie_in = 3'b001; set_req(8'b1111_1110); step("all pending");
    // R6: debug entry with global enable low keeps shadow
    ie_in = 3'b000; set_req(8'b0000_1000); step("watch ie low");
    // R7 and R8 with remap
    remap_in = 1; ie_in = 3'b001; set_req(8'b0010_0000); step("div remap");
    remap_in = 1; set_req(8'b0000_0010); step("brk remap");
    remap_in = 0; set_req(8'b0000_0010); step("brk no remap");
    remap_in = 0; set_req(8'b0001_0000); step("dbus no remap");
    set_req(8'h00); step("idle");

    for (int n = 0; n < 400; n++) begin
      logic [7:0] v;
      v = '0;
      for (int b = 1; b < 8; b++) v[b] = ($urandom % 4) == 0;
      set_req(v);
      ie_in    = 3'($urandom);
      remap_in = 1'($urandom);
      pc_in    = $urandom & 32'hffff_fffc;
      eba_in   = $urandom;
      deba_in  = $urandom;
      step("random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule